// File: doc/BRIEF.md
# Dual-Mode Stack Address Unit

This unit holds the processor's 16-bit stack pointer and turns stack operation requests into bus cycles. Each clock it accepts one request: push, pull, touch (a dummy stack read) or load. One cycle after it accepts a request, it presents the matching stack bus cycle and updates the pointer with the ordering that the operation needs. A push writes at the current pointer and steps the pointer down after the cycle. A pull steps the pointer up first and then reads at the new location.

The unit has two addressing modes. In native mode the full 16-bit pointer forms the bus address. In emulation mode the stack is confined to one fixed page: the address is page 0x01 joined with the low pointer byte, and any pointer update wraps inside that page. The load request copies a transfer value into the pointer. The value is trimmed to the current index width, and in emulation mode it is placed into the fixed page.

The control is a small sequencer with five named states. ST_IDLE means no bus cycle. ST_PUSH means a write cycle, with a decrement pending. ST_PULL means a read cycle at the already-incremented pointer. ST_TOUCH means a read cycle with no pointer change. ST_LOAD means the pointer was loaded and there is no bus cycle. Every state can move to every other state. The transition taken is set only by the request decoded in the current cycle: no request or a reserved code goes to ST_IDLE, push goes to ST_PUSH, pull goes to ST_PULL, touch goes to ST_TOUCH, and load goes to ST_LOAD.

Top module: `stk_addr_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, the pointer reads 0x01FF and no bus cycle is presented.
- R2: The request code on op_i is 0 for none, 1 for push, 2 for pull, 3 for touch and 4 for load. Codes 5 to 7 act as none. A request is accepted at every rising edge, and its bus cycle appears in the following cycle only, for exactly one cycle.
- R3: In native mode the bus address is the 16-bit pointer with bits 23:16 at zero.
- R4: In emulation mode the bus address is 0x000100 OR the low pointer byte, whatever the high pointer byte holds.
- R5: A push drives bus_we_o=1 at the current pointer address, and the pointer is one lower from the following cycle on.
- R6: A pull raises the pointer by one first, then reads (bus_we_o=0) at the address of the raised pointer. So a pull that directly follows a push reads the address that the push wrote.
- R7: A touch reads (bus_we_o=0) at the current pointer address and leaves the pointer unchanged.
- R8: A load in native mode with a wide index sets the pointer to all 16 bits of load_val_i. With a narrow index (idx_narrow_i=1) it sets the pointer to 0x00 followed by the low byte. In emulation mode it sets the pointer to 0x01 followed by the low byte.
- R9: In emulation mode a pointer step wraps only the low byte and forces the high byte to 0x01. For example, a push at 0x0100 leaves 0x01FF, and a pull from 0x34FF leaves 0x0100.
- R10: In native mode a pointer step wraps across all 16 bits. A push at 0x0000 leaves 0xFFFF, and a pull from 0xFFFF gives 0x0000.
- R11: In a cycle with no bus cycle (after none, a reserved code or a load), bus_valid_o, bus_we_o and bus_addr_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Request code (none, push, pull, touch, load) |
| emu_i | input | 1 | 1 selects emulation (single-page) addressing |
| idx_narrow_i | input | 1 | 1 when the index registers are 8 bits wide |
| load_val_i | input | 16 | Transfer value for a load request |
| bus_valid_o | output | 1 | A stack bus cycle is presented this cycle |
| bus_we_o | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr_o | output | 24 | Stack bus address |
| sp_o | output | 16 | Current stack pointer |

## Verification
Runs of back-to-back pushes and pulls check the asymmetric ordering: a pull right after a push must return the address the push wrote, which an inverted ordering gets wrong. Loads that place the pointer at 0x0000, at 0x0100 in emulation mode, and at a high byte other than 0x01 drive steps across both wrap boundaries. These show whether a step carries into the high byte and whether emulation addressing ignores that byte. Wide, narrow and emulation loads of the same value separate the three masking rules. The reserved codes and a mid-stream reset confirm that no unintended bus cycle or pointer change occurs.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PUSH  = 3'd1,
        ST_PULL  = 3'd2,
        ST_TOUCH = 3'd3,
        ST_LOAD  = 3'd4
    } stk_state_e;

    localparam logic [2:0] OPC_NONE  = 3'd0;
    localparam logic [2:0] OPC_PUSH  = 3'd1;
    localparam logic [2:0] OPC_PULL  = 3'd2;
    localparam logic [2:0] OPC_TOUCH = 3'd3;
    localparam logic [2:0] OPC_LOAD  = 3'd4;

endpackage

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op_i,
    input  logic       emu_i,
    output stk_state_e state_o,
    output logic       mode_o,
    output logic       bus_en_o,
    output logic       bus_wr_o,
    output logic       dec_pend_o
);

    stk_state_e state_q;
    stk_state_e state_d;
    logic       mode_q;

    // next-state selection from the decoded request
    always_comb begin
        unique case (op_i)
            OPC_PUSH:  state_d = ST_PUSH;
            OPC_PULL:  state_d = ST_PULL;
            OPC_TOUCH: state_d = ST_TOUCH;
            OPC_LOAD:  state_d = ST_LOAD;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register, with the mode captured alongside the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= emu_i;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        bus_en_o   = 1'b0;
        bus_wr_o   = 1'b0;
        dec_pend_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PUSH: begin
                bus_en_o   = 1'b1;
                bus_wr_o   = 1'b1;
                dec_pend_o = 1'b1;
            end
            ST_PULL:  bus_en_o = 1'b1;
            ST_TOUCH: bus_en_o = 1'b1;
            ST_LOAD:  ;
            default:  ;
        endcase
    end

    assign state_o = state_q;
    assign mode_o  = mode_q;

endmodule

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
    parameter int unsigned SP_W     = 16,
    parameter logic [SP_W/2-1:0] PAGE_HI = 8'h01,
    parameter logic [SP_W-1:0] RESET_SP = 16'h01FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_pend_i,
    input  logic            dec_mode_i,
    input  logic            pull_i,
    input  logic            load_i,
    input  logic            emu_i,
    input  logic            narrow_i,
    input  logic [SP_W-1:0] load_val_i,
    output logic [SP_W-1:0] sp_o
);

    localparam int unsigned HALF = SP_W / 2;
    localparam logic [HALF-1:0] LO_ONE = {{(HALF-1){1'b0}}, 1'b1};
    localparam logic [SP_W-1:0] SP_ONE = {{(SP_W-1){1'b0}}, 1'b1};
    localparam logic [SP_W-HALF-1:0] HI_ZERO = '0;

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] after_dec;
    logic [SP_W-1:0] sp_d;

    function automatic logic [SP_W-1:0] step(input logic [SP_W-1:0] v,
                                             input logic up,
                                             input logic emu);
        logic [HALF-1:0] lo;
        logic [SP_W-1:0] full;
        lo   = up ? (v[HALF-1:0] + LO_ONE) : (v[HALF-1:0] - LO_ONE);
        full = up ? (v + SP_ONE) : (v - SP_ONE);
        return emu ? {PAGE_HI, lo} : full;
    endfunction

    // post-decrement of a push completes at the end of its bus cycle
    always_comb begin
        after_dec = dec_pend_i ? step(sp_q, 1'b0, dec_mode_i) : sp_q;
    end

    always_comb begin
        if (load_i) begin
            if (emu_i)
                sp_d = {PAGE_HI, load_val_i[HALF-1:0]};
            else if (narrow_i)
                sp_d = {HI_ZERO, load_val_i[HALF-1:0]};
            else
                sp_d = load_val_i;
        end else if (pull_i) begin
            sp_d = step(after_dec, 1'b1, emu_i);
        end else begin
            sp_d = after_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= RESET_SP;
        else        sp_q <= sp_d;
    end

    assign sp_o = sp_q;

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int unsigned SP_W   = 16,
    parameter int unsigned BANK_W = 8,
    parameter logic [SP_W/2-1:0] PAGE_HI = 8'h01
) (
    input  logic                   bus_en_i,
    input  logic                   mode_i,
    input  logic [SP_W-1:0]        sp_i,
    output logic [BANK_W+SP_W-1:0] addr_o
);

    localparam int unsigned HALF   = SP_W / 2;
    localparam int unsigned ADDR_W = BANK_W + SP_W;
    localparam logic [BANK_W-1:0] BANK_ZERO = '0;

    always_comb begin
        if (!bus_en_i)
            addr_o = '0;
        else if (mode_i)
            addr_o = {BANK_ZERO, PAGE_HI, sp_i[HALF-1:0]};
        else
            addr_o = {BANK_ZERO, sp_i};
    end

    logic [ADDR_W-1:0] unused_w;
    assign unused_w = addr_o;

endmodule

// File: rtl/stk_addr_unit.sv
module stk_addr_unit #(
    parameter int unsigned SP_W   = 16,
    parameter int unsigned BANK_W = 8,
    parameter logic [SP_W/2-1:0] PAGE_HI  = 8'h01,
    parameter logic [SP_W-1:0]   RESET_SP = 16'h01FF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             op_i,
    input  logic                   emu_i,
    input  logic                   idx_narrow_i,
    input  logic [SP_W-1:0]        load_val_i,
    output logic                   bus_valid_o,
    output logic                   bus_we_o,
    output logic [BANK_W+SP_W-1:0] bus_addr_o,
    output logic [SP_W-1:0]        sp_o
);

    import stk_pkg::*;

    stk_state_e state_w;
    logic       mode_w;
    logic       bus_en_w;
    logic       bus_wr_w;
    logic       dec_pend_w;
    logic [SP_W-1:0] sp_w;

    stk_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .emu_i      (emu_i),
        .state_o    (state_w),
        .mode_o     (mode_w),
        .bus_en_o   (bus_en_w),
        .bus_wr_o   (bus_wr_w),
        .dec_pend_o (dec_pend_w)
    );

    stk_ptr_reg #(
        .SP_W     (SP_W),
        .PAGE_HI  (PAGE_HI),
        .RESET_SP (RESET_SP)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_pend_i (dec_pend_w),
        .dec_mode_i (mode_w),
        .pull_i     (op_i == OPC_PULL),
        .load_i     (op_i == OPC_LOAD),
        .emu_i      (emu_i),
        .narrow_i   (idx_narrow_i),
        .load_val_i (load_val_i),
        .sp_o       (sp_w)
    );

    stk_addr_gen #(
        .SP_W    (SP_W),
        .BANK_W  (BANK_W),
        .PAGE_HI (PAGE_HI)
    ) u_addr (
        .bus_en_i (bus_en_w),
        .mode_i   (mode_w),
        .sp_i     (sp_w),
        .addr_o   (bus_addr_o)
    );

    assign bus_valid_o = bus_en_w;
    assign bus_we_o    = bus_wr_w;
    assign sp_o        = sp_w;

    stk_state_e unused_state;
    assign unused_state = state_w;

endmodule

// File: rtl/stk_addr_unit_chk.sv
module stk_addr_unit_chk #(
    parameter int unsigned SP_W   = 16,
    parameter int unsigned BANK_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2:0]             op_i,
    input logic                   emu_i,
    input logic                   bus_valid_o,
    input logic                   bus_we_o,
    input logic [BANK_W+SP_W-1:0] bus_addr_o,
    input logic [SP_W-1:0]        sp_o
);

    localparam int unsigned HALF = SP_W / 2;

    AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_o[BANK_W+SP_W-1:SP_W] == '0); // R3

    AST_EMU_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(emu_i) && bus_valid_o) |-> (bus_addr_o[SP_W-1:HALF] == 1)); // R4

    AST_PUSH_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_i) == 3'd1) |-> (bus_valid_o && bus_we_o)); // R5

    AST_PULL_AT_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_i) == 3'd2 && !$past(emu_i)) |-> (bus_valid_o && !bus_we_o && bus_addr_o[SP_W-1:0] == sp_o)); // R6

    AST_TOUCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_i) == 3'd3 && !($past(bus_valid_o) && $past(bus_we_o))) |-> (bus_valid_o && !bus_we_o && $stable(sp_o))); // R7

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_i) == 3'd0 || $past(op_i) > 3'd3) |-> (!bus_valid_o && !bus_we_o && bus_addr_o == '0)); // R11

endmodule

bind stk_addr_unit stk_addr_unit_chk #(
    .SP_W   (SP_W),
    .BANK_W (BANK_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .emu_i       (emu_i),
    .bus_valid_o (bus_valid_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .sp_o        (sp_o)
);

// File: tb/stk_addr_unit_tb.sv
module stk_addr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic        emu_i = 1'b0;
    logic        idx_narrow_i = 1'b0;
    logic [15:0] load_val_i = 16'h0000;
    logic        bus_valid_o;
    logic        bus_we_o;
    logic [23:0] bus_addr_o;
    logic [15:0] sp_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stk_addr_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op_i),
        .emu_i        (emu_i),
        .idx_narrow_i (idx_narrow_i),
        .load_val_i   (load_val_i),
        .bus_valid_o  (bus_valid_o),
        .bus_we_o     (bus_we_o),
        .bus_addr_o   (bus_addr_o),
        .sp_o         (sp_o)
    );

    // op, emu, narrow, value, exp valid, exp we, exp addr, exp sp, tag
    localparam int NV = 22;
    localparam logic [66:0] VEC [NV] = '{
        {3'd1,1'b0,1'b0,16'h0000,1'b1,1'b1,24'h0001FF,16'h01FF,4'd5},
        {3'd1,1'b0,1'b0,16'h0000,1'b1,1'b1,24'h0001FE,16'h01FE,4'd5},
        {3'd2,1'b0,1'b0,16'h0000,1'b1,1'b0,24'h0001FE,16'h01FE,4'd6},
        {3'd3,1'b0,1'b0,16'h0000,1'b1,1'b0,24'h0001FE,16'h01FE,4'd7},
        {3'd4,1'b0,1'b0,16'h1234,1'b0,1'b0,24'h000000,16'h1234,4'd8},
        {3'd1,1'b0,1'b0,16'h0000,1'b1,1'b1,24'h001234,16'h1234,4'd3},
        {3'd2,1'b0,1'b0,16'h0000,1'b1,1'b0,24'h001234,16'h1234,4'd6},
        {3'd4,1'b0,1'b1,16'hABCD,1'b0,1'b0,24'h000000,16'h00CD,4'd8},
        {3'd0,1'b0,1'b0,16'h0000,1'b0,1'b0,24'h000000,16'h00CD,4'd11},
        {3'd4,1'b0,1'b0,16'h0000,1'b0,1'b0,24'h000000,16'h0000,4'd8},
        {3'd1,1'b0,1'b0,16'h0000,1'b1,1'b1,24'h000000,16'h0000,4'd5},
        {3'd0,1'b0,1'b0,16'h0000,1'b0,1'b0,24'h000000,16'hFFFF,4'd10},
        {3'd2,1'b0,1'b0,16'h0000,1'b1,1'b0,24'h000000,16'h0000,4'd10},
        {3'd4,1'b1,1'b0,16'h5600,1'b0,1'b0,24'h000000,16'h0100,4'd8},
        {3'd1,1'b1,1'b0,16'h0000,1'b1,1'b1,24'h000100,16'h0100,4'd4},
        {3'd0,1'b1,1'b0,16'h0000,1'b0,1'b0,24'h000000,16'h01FF,4'd9},
        {3'd2,1'b1,1'b0,16'h0000,1'b1,1'b0,24'h000100,16'h0100,4'd9},
        {3'd4,1'b0,1'b0,16'h34FF,1'b0,1'b0,24'h000000,16'h34FF,4'd8},
        {3'd3,1'b1,1'b0,16'h0000,1'b1,1'b0,24'h0001FF,16'h34FF,4'd4},
        {3'd2,1'b1,1'b0,16'h0000,1'b1,1'b0,24'h000100,16'h0100,4'd9},
        {3'd5,1'b0,1'b0,16'hFFFF,1'b0,1'b0,24'h000000,16'h0100,4'd2},
        {3'd7,1'b0,1'b0,16'hFFFF,1'b0,1'b0,24'h000000,16'h0100,4'd2}
    };

    function automatic string tag(input logic [3:0] n);
        case (n)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic expect_out(input string req, input logic v, input logic we,
                              input logic [23:0] a, input logic [15:0] s);
        checks++;
        if (bus_valid_o !== v || bus_we_o !== we || bus_addr_o !== a || sp_o !== s) begin
            errors++;
            $display("FAIL %s: got valid=%0b we=%0b addr=%06h sp=%04h, expected valid=%0b we=%0b addr=%06h sp=%04h",
                     req, bus_valid_o, bus_we_o, bus_addr_o, sp_o, v, we, a, s);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_out("R1", 1'b0, 1'b0, 24'h0, 16'h01FF); // R1 during reset
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        expect_out("R1", 1'b0, 1'b0, 24'h0, 16'h01FF); // R1 first cycle after reset

        for (int i = 0; i < NV; i++) begin
            op_i         = VEC[i][66:64];
            emu_i        = VEC[i][63];
            idx_narrow_i = VEC[i][62];
            load_val_i   = VEC[i][61:46];
            @(posedge clk);
            @(negedge clk);
            expect_out(tag(VEC[i][3:0]), VEC[i][45], VEC[i][44], VEC[i][43:20], VEC[i][19:4]);
        end

        // R2: the bus cycle lasts one cycle only
        op_i = 3'd3; emu_i = 1'b0;
        @(posedge clk); @(negedge clk);
        op_i = 3'd0;
        @(posedge clk); @(negedge clk);
        expect_out("R2", 1'b0, 1'b0, 24'h0, 16'h0100);

        // R1: reset in the middle of a push returns to the reset state
        op_i = 3'd1;
        @(posedge clk); @(negedge clk);
        op_i = 3'd0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        expect_out("R1", 1'b0, 1'b0, 24'h0, 16'h01FF);
        rst_n = 1'b1;

        // R6: pull directly after a push reads the pushed address
        op_i = 3'd1;
        @(posedge clk); @(negedge clk);
        op_i = 3'd2;
        @(posedge clk); @(negedge clk);
        expect_out("R6", 1'b1, 1'b0, 24'h0001FF, 16'h01FF);
        op_i = 3'd0;
        @(posedge clk); @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule